// File: doc/BRIEF.md
# Serial Configuration Length-Count Controller

This block sits on the serial configuration input of a programmable device. A single configuration clock samples one data-in bit per rising edge. The block searches the stream for a run of high bits, then a 4-bit start code, then a 24-bit total length. It then gathers the bits that follow into fixed-width words for its own configuration memory. Each word leaves the block as a one-cycle write strobe with the word beside it.

Every rising edge since reset is counted. Once the block has written all of its own words, the bits that follow are meant for devices further down a daisy chain. The block forwards them on data-out, which changes on the falling clock edge. Configuration ends when the running count equals the loaded length. At that point the done flag, the user-logic reset release and the two during-configuration indicator pins change. Two small selects move the done flag and the reset release, each on its own, to one clock earlier or one clock later than the nominal point.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low: `cfg_done`=0, `user_rst_n`=0, `hdc`=1, `ldc`=0, `dout`=1 and `frame_we`=0.
- R2: Header lock needs at least PRE_ONES (8) consecutive 1 bits, then the start code 0010 sent left bit first (its first bit is the 0 that ends the run), then LEN_W (24) length bits sent most significant bit first. A 0 that arrives before the run is long enough clears the run.
- R3: If a code bit does not match, the block goes back to looking for preamble ones with the run counter at zero. The clock count is not cleared, so the length still counts every edge since reset.
- R4: After the header, each group of FRAME_BITS bits becomes one word, with the first bit as the MSB. `frame_we` pulses for one cycle after the edge that takes in the last bit of the group, with that word on `frame_data`. Exactly OWN_FRAMES words are written.
- R5: `dout` changes on the falling edge and carries the bit sampled at the rising edge just before it. That bit is forwarded for header bits and for bits after the own words. It is replaced by 1 for bits that belong to the block's own words. `dout` is 1 from reset until the first falling edge.
- R6: The matching edge is the rising edge after which the count of edges since reset equals the loaded length and all own words are written. Done never asserts before this edge.
- R7: `done_sel` sets when `cfg_done` rises, counted from the matching edge E: 1 means at E, 2 means at E+2, and 0 or 3 mean at E+1.
- R8: `urst_sel` sets when `user_rst_n` rises, using the same encoding as R7 and independent of `done_sel`.
- R9: `hdc` is the inverse of `cfg_done` and `ldc` follows `cfg_done`.
- R10: After the matching edge, the count stops. `cfg_done` and `user_rst_n` stay high, no further `frame_we` pulse occurs, and later input bits keep being forwarded on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low start of configuration |
| din | input | 1 | Serial configuration data in |
| done_sel | input | 2 | Done timing select (0/3 nominal, 1 early, 2 late) |
| urst_sel | input | 2 | User reset release timing select, same encoding |
| dout | output | 1 | Serial data out to the next device, falling-edge timed |
| frame_we | output | 1 | One-cycle write strobe for an own configuration word |
| frame_data | output | FRAME_BITS | Assembled configuration word |
| cfg_done | output | 1 | Configuration complete |
| user_rst_n | output | 1 | Active-low reset to user flip-flops, released at completion |
| hdc | output | 1 | High during configuration |
| ldc | output | 1 | Low during configuration |

## Verification
A wrong header phase shows up at the ports within one word time. If the block locks early or late, the first `frame_we` strobe moves and `dout` stops echoing a header bit or drops its forced-high stretch. A count that is off by any amount, or a code mismatch that clears it, moves the completion edge by the same number of clocks. The bench therefore checks done and reset-release on every edge against an edge number it computes itself. A bad frame boundary corrupts `frame_data` on the very next strobe.

// File: rtl/cfgl_pkg.sv
`timescale 1ns/1ps
package cfgl_pkg;

  typedef enum logic [2:0] {
    PH_SEEK,
    PH_CODE,
    PH_LEN,
    PH_LOAD,
    PH_PASS
  } phase_e;

  // Timing select: 1 = early, 2 = late, others = nominal
  function automatic logic pick_stage(input logic [1:0] sel, input logic early_v,
                                      input logic nom_v, input logic late_v);
    case (sel)
      2'd1:    return early_v;
      2'd2:    return late_v;
      default: return nom_v;
    endcase
  endfunction

endpackage

// File: rtl/cfgl_hdr.sv
`timescale 1ns/1ps
module cfgl_hdr
  import cfgl_pkg::*;
#(
  parameter int PRE_ONES = 8,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] START_CODE = 4'b0010,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             all_fin,
  output phase_e           phase,
  output logic [LEN_W-1:0] len_q
);
  localparam int ONE_W = $clog2(PRE_ONES + 1);
  localparam int CI_W = $clog2(CODE_W);
  localparam int LI_W = $clog2(LEN_W);
  localparam logic [CODE_W-1:0] CODE_REV = {<<{START_CODE}};

  logic [ONE_W-1:0] ones;
  logic [CI_W-1:0]  cidx;
  logic [LI_W-1:0]  lidx;
  logic             code_bit;
  logic             run_full;

  assign code_bit = CODE_REV[cidx];
  assign run_full = (ones == ONE_W'(PRE_ONES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SEEK;
      ones  <= '0;
      cidx  <= '0;
      lidx  <= '0;
      len_q <= '0;
    end else begin
      case (phase)
        PH_SEEK: begin
          if (din) begin
            if (!run_full) ones <= ones + 1'b1;
          end else if (run_full) begin
            phase <= PH_CODE;
            cidx  <= CI_W'(1);
            ones  <= '0;
          end else begin
            ones <= '0;
          end
        end
        PH_CODE: begin
          if (din == code_bit) begin
            if (cidx == CI_W'(CODE_W - 1)) begin
              phase <= PH_LEN;
              lidx  <= '0;
            end else begin
              cidx <= cidx + 1'b1;
            end
          end else begin
            phase <= PH_SEEK;
            ones  <= '0;
          end
        end
        PH_LEN: begin
          len_q <= {len_q[LEN_W-2:0], din};
          if (lidx == LI_W'(LEN_W - 1)) phase <= PH_LOAD;
          else lidx <= lidx + 1'b1;
        end
        PH_LOAD: if (all_fin) phase <= PH_PASS;
        default: ;
      endcase
    end
  end

  AST_LEN_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEN && $past(phase) != PH_LEN) |-> $past(phase) == PH_CODE); // R2
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PASS) |=> (phase == PH_PASS)); // R10
endmodule

// File: rtl/cfgl_frame.sv
`timescale 1ns/1ps
module cfgl_frame #(
  parameter int FRAME_BITS = 8,
  parameter int OWN_FRAMES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic                  load_en,
  output logic                  all_fin,
  output logic                  own_done,
  output logic                  frame_we,
  output logic [FRAME_BITS-1:0] frame_data
);
  localparam int BP_W = $clog2(FRAME_BITS);
  localparam int FC_W = $clog2(OWN_FRAMES + 1);

  logic [BP_W-1:0]       bitpos;
  logic [FC_W-1:0]       fcnt;
  logic [FRAME_BITS-1:0] word;
  logic                  last_bit;

  assign last_bit = load_en && (bitpos == BP_W'(FRAME_BITS - 1));
  assign all_fin  = last_bit && (fcnt == FC_W'(OWN_FRAMES - 1));
  assign own_done = (fcnt == FC_W'(OWN_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos     <= '0;
      fcnt       <= '0;
      word       <= '0;
      frame_we   <= 1'b0;
      frame_data <= '0;
    end else begin
      frame_we <= 1'b0;
      if (load_en) begin
        word <= {word[FRAME_BITS-2:0], din};
        if (last_bit) begin
          bitpos     <= '0;
          fcnt       <= fcnt + 1'b1;
          frame_we   <= 1'b1;
          frame_data <= {word[FRAME_BITS-2:0], din};
        end else begin
          bitpos <= bitpos + 1'b1;
        end
      end
    end
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |=> !frame_we); // R4
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FC_W'(OWN_FRAMES)); // R4
  AST_NO_LOAD_AFTER_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    own_done |-> !load_en); // R4
endmodule

// File: rtl/cfgl_finish.sv
`timescale 1ns/1ps
module cfgl_finish
  import cfgl_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_q,
  input  logic             own_done,
  input  logic [1:0]       done_sel,
  input  logic [1:0]       urst_sel,
  output logic             cfg_done,
  output logic             user_rst_n
);
  logic [LEN_W-1:0] cnt;
  logic             hit;
  logic             stage_e;
  logic             stage_n;
  logic             stage_l;

  assign hit     = own_done && (cnt == len_q);
  assign stage_e = hit | stage_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stage_n <= 1'b0;
      stage_l <= 1'b0;
    end else begin
      if (!hit) cnt <= cnt + 1'b1;
      stage_n <= stage_n | hit;
      stage_l <= stage_n;
    end
  end

  assign cfg_done   = pick_stage(done_sel, stage_e, stage_n, stage_l);
  assign user_rst_n = pick_stage(urst_sel, stage_e, stage_n, stage_l);

  AST_DONE_NEEDS_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    stage_n |-> own_done); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stage_n |=> stage_n); // R10
  AST_LATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    stage_l |-> stage_n); // R7
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> $stable(cnt)); // R10
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int PRE_ONES = 8,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] START_CODE = 4'b0010,
  parameter int LEN_W = 24,
  parameter int FRAME_BITS = 8,
  parameter int OWN_FRAMES = 4
) (
  input  logic                  cclk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic [1:0]            done_sel,
  input  logic [1:0]            urst_sel,
  output logic                  dout,
  output logic                  frame_we,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  cfg_done,
  output logic                  user_rst_n,
  output logic                  hdc,
  output logic                  ldc
);
  phase_e           phase;
  logic [LEN_W-1:0] len_q;
  logic             all_fin;
  logic             own_done;
  logic             load_en;
  logic             out_bit;

  assign load_en = (phase == PH_LOAD);

  cfgl_hdr #(
    .PRE_ONES(PRE_ONES), .CODE_W(CODE_W), .START_CODE(START_CODE), .LEN_W(LEN_W)
  ) u_hdr (
    .clk(cclk), .rst_n(rst_n), .din(din), .all_fin(all_fin),
    .phase(phase), .len_q(len_q)
  );

  cfgl_frame #(
    .FRAME_BITS(FRAME_BITS), .OWN_FRAMES(OWN_FRAMES)
  ) u_frame (
    .clk(cclk), .rst_n(rst_n), .din(din), .load_en(load_en),
    .all_fin(all_fin), .own_done(own_done),
    .frame_we(frame_we), .frame_data(frame_data)
  );

  cfgl_finish #(
    .LEN_W(LEN_W)
  ) u_finish (
    .clk(cclk), .rst_n(rst_n), .len_q(len_q), .own_done(own_done),
    .done_sel(done_sel), .urst_sel(urst_sel),
    .cfg_done(cfg_done), .user_rst_n(user_rst_n)
  );

  // Rising edge captures the bit to forward; own-word bits become 1
  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) out_bit <= 1'b1;
    else        out_bit <= load_en ? 1'b1 : din;
  end

  // Falling edge drives the chain output
  always_ff @(negedge cclk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b1;
    else        dout <= out_bit;
  end

  assign hdc = ~cfg_done;
  assign ldc = cfg_done;

  AST_DONE_AFTER_OWN: assert property (@(posedge cclk) disable iff (!rst_n)
    (cfg_done && done_sel != 2'd1) |-> own_done); // R6
endmodule

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
  localparam int F = 8;
  localparam int N = 4;
  localparam int HDR = 36;
  localparam logic [27:0] VEC [0:3] = '{
    {24'd68, 2'd0, 2'd0},
    {24'd75, 2'd1, 2'd2},
    {24'd90, 2'd2, 2'd1},
    {24'd70, 2'd3, 2'd1}
  };

  logic cclk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic [1:0] done_sel = 2'd0;
  logic [1:0] urst_sel = 2'd0;
  logic dout, frame_we, cfg_done, user_rst_n, hdc, ldc;
  logic [F-1:0] frame_data;

  int n_tests = 0;
  int n_fail = 0;
  logic sb [0:511];
  int sl = 0;

  always #2.5 cclk = ~cclk;

  serial_cfg_loader u_serial_cfg_loader (
    .cclk(cclk), .rst_n(rst_n), .din(din), .done_sel(done_sel), .urst_sel(urst_sel),
    .dout(dout), .frame_we(frame_we), .frame_data(frame_data),
    .cfg_done(cfg_done), .user_rst_n(user_rst_n), .hdc(hdc), .ldc(ldc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic b);
    sb[sl] = b;
    sl++;
  endtask

  task automatic push_hdr(input int len);
    for (int i = 0; i < 8; i++) push(1'b1);
    push(1'b0); push(1'b0); push(1'b1); push(1'b0);
    for (int i = 23; i >= 0; i--) push(len[i]);
  endtask

  task automatic push_frames(input int seed);
    for (int w = 0; w < N; w++) begin
      logic [7:0] v;
      v = 8'(seed + w * 37);
      for (int i = F - 1; i >= 0; i--) push(v[i]);
    end
  endtask

  function automatic int sel_off(input logic [1:0] s);
    if (s == 2'd1) return 0;
    if (s == 2'd2) return 2;
    return 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    din = 1'b0;
    repeat (2) @(posedge cclk);
    @(negedge cclk);
    #1;
    // R1: reset state at the ports
    chk("R1 done", 32'(cfg_done), 0);
    chk("R1 urst", 32'(user_rst_n), 0);
    chk("R1 hdc", 32'(hdc), 1);
    chk("R1 ldc", 32'(ldc), 0);
    chk("R1 dout", 32'(dout), 1);
    chk("R1 we", 32'(frame_we), 0);
    rst_n = 1'b1;
  endtask

  // Plays sb[0..sl-1]; hdr_end = edge of last length bit, e = matching edge
  task automatic play(input int hdr_end, input int e, input string first_tag);
    int ed, er, fend;
    ed = e + sel_off(done_sel);
    er = e + sel_off(urst_sel);
    fend = hdr_end + F * N;
    for (int k = 1; k <= sl; k++) begin
      din = sb[k-1];
      @(posedge cclk);
      #1;
      if (k > hdr_end && k <= fend && ((k - hdr_end) % F) == 0) begin
        logic [F-1:0] w;
        for (int j = 0; j < F; j++) w[F-1-j] = sb[k-F+j];
        chk((k == hdr_end + F) ? first_tag : "R4", 32'(frame_we), 1);
        chk("R4 data", 32'(frame_data), 32'(w));
      end else begin
        chk((k > e) ? "R10 we" : "R4 we", 32'(frame_we), 0);
      end
      chk((k < e) ? "R6" : ((k <= ed) ? "R7" : "R10"), 32'(cfg_done), 32'(k >= ed));
      chk((k <= er) ? "R8" : "R10 urst", 32'(user_rst_n), 32'(k >= er));
      chk("R9 hdc", 32'(hdc), 32'(k < ed));
      chk("R9 ldc", 32'(ldc), 32'(k >= ed));
      @(negedge cclk);
      #1;
      chk((k > e) ? "R10 dout" : "R5", 32'(dout),
          32'((k > hdr_end && k <= fend) ? 1'b1 : sb[k-1]));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // Table-driven runs: clean header, various lengths and timing selects
    for (int r = 0; r < 4; r++) begin
      int len;
      len = int'(VEC[r][27:4]);
      done_sel = VEC[r][3:2];
      urst_sel = VEC[r][1:0];
      do_reset();
      sl = 0;
      push_hdr(len);
      push_frames(90 + r * 11);
      while (sl < len + 5) push(1'(((sl >> 1) ^ sl) & 1));
      play(HDR, len, "R2 first word");
    end

    // R2/R3: short run of ones, then a code mismatch, then a real header
    done_sel = 2'd0;
    urst_sel = 2'd2;
    do_reset();
    sl = 0;
    for (int i = 0; i < 5; i++) push(1'b1);
    push(1'b0);
    for (int i = 0; i < 8; i++) push(1'b1);
    push(1'b0); push(1'b0); push(1'b1); push(1'b1);
    push_hdr(90);
    push_frames(200);
    while (sl < 96) push(1'(sl & 1));
    play(18 + HDR, 90, "R3 first word");

    // R1: reset after completion returns the idle state
    do_reset();
    @(posedge cclk);
    #1;
    chk("R1 hold", 32'(cfg_done), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule